// File: doc/BRIEF.md
# Masked Vector Arithmetic Unit

This unit holds a small bank of vector registers and runs element-wise integer operations over them. An operation reads two source registers, or one source register and a 64-bit scalar. A length register sets how many leading elements the operation covers. A mask register holds one bit per element and decides which destination elements may be written. Each register's elements are spread across parallel lanes, so element i lives in lane i mod L. Each lane handles one element per cycle, which makes an operation of length n take ceil(n/L) issue beats.

Three arithmetic operations write a destination register: vector plus vector, vector minus vector, and vector plus scalar. A not-equal compare against the scalar writes the mask instead of a register. A mask-fill operation sets every mask bit to one. Where the mask bit is zero, the element still uses its beat, but its destination is not written.

A host fills and inspects the registers through an element write port and a registered element read port. It sets the length between operations and issues one operation at a time, waiting for the done pulse before the next.

Top module: `masked_vec_alu`

## Requirements
- R1: After reset, busy and done are 0 and mask_o is all ones. The length is 64, so an operation issued before any length write covers all 64 elements.
- R2: Op codes on cmd_op: 0 writes vd[i]=vs1[i]+vs2[i], 1 writes vd[i]=vs1[i]-vs2[i], and 2 writes vd[i]=vs1[i]+cmd_scalar. All results are modulo 2^64, and each is written only for elements i below the length whose mask bit i is 1.
- R3: A destination element whose mask bit is 0 keeps its value. The operation takes the same number of cycles whatever the mask holds.
- R4: Destination elements at index length or above are left unchanged, and a length of 0 writes nothing. A length write (vl_we) with a value above 64 sets the length to 64.
- R5: Op code 3 sets mask bit i to 1 when vs1[i] differs from cmd_scalar and to 0 otherwise, for every i below the length. Mask bits at index length or above keep their values, and no register changes.
- R6: Op code 4 sets all 64 mask bits to 1 regardless of the length, and changes no register.
- R7: Let E0 be the clock edge that accepts a command, and let K = max(ceil(n/4),1)+1 with n the length (K = 2 for op code 4). busy is 1 from after E0 until done. done is 1 for exactly the one cycle after edge E0+K, and busy is 0 in that cycle.
- R8: While busy is 1, commands, length writes and element writes are ignored. A command with op code 5, 6 or 7 is never accepted: busy stays 0 and nothing changes.
- R9: Register element (rd_reg, rd_idx) appears on rd_data in the cycle after the edge that samples the address. An element write (ld_we) made while idle is visible to later reads and operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vl_we | input | 1 | Load a new length when idle |
| vl_in | input | 7 | Length value, capped at 64 |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Operation code |
| cmd_vd | input | 2 | Destination register |
| cmd_vs1 | input | 2 | First source register |
| cmd_vs2 | input | 2 | Second source register |
| cmd_scalar | input | 64 | Scalar operand |
| ld_we | input | 1 | Element write strobe |
| ld_reg | input | 2 | Element write register |
| ld_idx | input | 6 | Element write index |
| ld_data | input | 64 | Element write data |
| rd_reg | input | 2 | Element read register |
| rd_idx | input | 6 | Element read index |
| rd_data | output | 64 | Element read data, one cycle later |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle completion pulse |
| mask_o | output | 64 | Current mask register |

## Verification
The arithmetic is tried four ways. An all-ones mask checks the raw sums and differences. A random mask, built by a compare against zero, separates gating from computing, and because the beat count must not change it also shows that masked-off elements keep their slots. A sweep of lengths across lane-boundary values (0, 1, 3, 4, 5, 17, 63, 64 and a capped 100) separates length trimming from lane striping and checks the beat count. A conditional subtract followed by a mask fill checks the compare, the masked write and the mask fill working in sequence.

// File: rtl/mvu_pkg.sv
// Shared operation codes for the masked vector arithmetic unit.
// Assumes a 3-bit command code; codes 5..7 are reserved and rejected.
package mvu_pkg;

    typedef enum logic [2:0] {
        OP_VV_ADD    = 3'd0,
        OP_VV_SUB    = 3'd1,
        OP_VS_ADD    = 3'd2,
        OP_VS_NEQ    = 3'd3,
        OP_MASK_ONES = 3'd4
    } vop_e;

    // True for codes that write a destination register
    function automatic logic op_writes_reg(input vop_e op);
        return (op == OP_VV_ADD) || (op == OP_VV_SUB) || (op == OP_VS_ADD);
    endfunction

    // True for codes the unit accepts
    function automatic logic op_known(input logic [2:0] code);
        return code <= 3'd4;
    endfunction

endpackage

// File: rtl/mvu_seq.sv
// Operation sequencer: accepts one command at a time, holds the length
// register, issues ceil(len/LANES) read beats, then walks each beat through
// one write stage and emits a done pulse. Assumes LANES is a power of two
// that divides MVL and is at least 2.
module mvu_seq
    import mvu_pkg::*;
#(
    parameter int W     = 64,
    parameter int MVL   = 64,
    parameter int LANES = 4,
    parameter int NREG  = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           vl_we,
    input  logic [$clog2(MVL+1)-1:0]       vl_in,
    input  logic                           cmd_valid,
    input  logic [2:0]                     cmd_op,
    input  logic [$clog2(NREG)-1:0]        cmd_vd,
    input  logic [$clog2(NREG)-1:0]        cmd_vs1,
    input  logic [$clog2(NREG)-1:0]        cmd_vs2,
    input  logic [W-1:0]                   cmd_scalar,
    output logic                           iss_valid,
    output logic [$clog2(NREG)+$clog2(MVL/LANES)-1:0] ra_row,
    output logic [$clog2(NREG)+$clog2(MVL/LANES)-1:0] rb_row,
    output logic                           s1_valid,
    output logic [$clog2(MVL/LANES)-1:0]   s1_beat,
    output vop_e                           s1_op,
    output logic [$clog2(NREG)+$clog2(MVL/LANES)-1:0] wr_row,
    output logic [W-1:0]                   s1_scalar,
    output logic [$clog2(MVL+1)-1:0]       vl_q,
    output logic                           cmp_en,
    output logic                           clr_fire,
    output logic                           busy,
    output logic                           done
);
    localparam int LG    = $clog2(LANES);
    localparam int DEPTH = MVL / LANES;
    localparam int DW    = $clog2(DEPTH);
    localparam int RW    = $clog2(NREG);
    localparam int VLW   = $clog2(MVL+1);
    localparam int BW    = $clog2(DEPTH+1);

    logic            run;
    logic [BW-1:0]   beat, nb, beat_nxt, nb_calc;
    logic [RW-1:0]   vd_q, vs1_q, vs2_q;
    logic            s1_last, done_q;
    logic            accept;
    logic [VLW:0]    vl_round;

    // Beat count for the current length, rounded up to whole lane groups
    always_comb begin
        vl_round = {1'b0, vl_q} + (VLW+1)'(LANES-1);
        nb_calc  = BW'(vl_round >> LG);
        beat_nxt = beat + BW'(1);
    end

    assign busy     = run | s1_valid | s1_last;
    assign accept   = cmd_valid && !busy && op_known(cmd_op);
    assign iss_valid = run && (beat < nb);
    assign ra_row   = {vs1_q, beat[DW-1:0]};
    assign rb_row   = {vs2_q, beat[DW-1:0]};
    assign wr_row   = {vd_q, s1_beat};
    assign cmp_en   = s1_valid && (s1_op == OP_VS_NEQ);
    assign clr_fire = s1_last && (s1_op == OP_MASK_ONES);
    assign done     = done_q;

    // Command capture, beat issue, write-stage tracking and length register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run       <= 1'b0;
            beat      <= '0;
            nb        <= '0;
            vd_q      <= '0;
            vs1_q     <= '0;
            vs2_q     <= '0;
            s1_op     <= OP_VV_ADD;
            s1_scalar <= '0;
            vl_q      <= VLW'(MVL);
            s1_valid  <= 1'b0;
            s1_last   <= 1'b0;
            s1_beat   <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= s1_last;
            if (vl_we && !busy)
                vl_q <= (vl_in > VLW'(MVL)) ? VLW'(MVL) : vl_in;
            if (accept) begin
                run       <= 1'b1;
                beat      <= '0;
                nb        <= (vop_e'(cmd_op) == OP_MASK_ONES) ? '0 : nb_calc;
                vd_q      <= cmd_vd;
                vs1_q     <= cmd_vs1;
                vs2_q     <= cmd_vs2;
                s1_op     <= vop_e'(cmd_op);
                s1_scalar <= cmd_scalar;
            end
            if (run) begin
                s1_valid <= (beat < nb);
                s1_last  <= (beat_nxt >= nb);
                s1_beat  <= beat[DW-1:0];
                beat     <= beat_nxt;
                if (beat_nxt >= nb)
                    run <= 1'b0;
            end else begin
                s1_valid <= 1'b0;
                s1_last  <= 1'b0;
            end
        end
    end

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy);
    a_r7_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);
    a_r8_len_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(vl_q));
    a_r4_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
        vl_q <= VLW'(MVL));

endmodule

// File: rtl/mvu_lane.sv
// One lane: a bank holding this lane's share of every vector register
// (element i of register r at row r*DEPTH + i/LANES), an operand stage
// filled on issue beats and a write stage that computes and commits one
// element per cycle. Host writes are assumed to arrive only while idle.
module mvu_lane
    import mvu_pkg::*;
#(
    parameter int W   = 64,
    parameter int AW  = 6,
    parameter int EW  = 6,
    parameter int VLW = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ld_we,
    input  logic [AW-1:0]  ld_row,
    input  logic [W-1:0]   ld_data,
    input  logic [AW-1:0]  rd_row,
    output logic [W-1:0]   rd_data,
    input  logic           iss_valid,
    input  logic [AW-1:0]  ra_row,
    input  logic [AW-1:0]  rb_row,
    input  logic           s1_valid,
    input  vop_e           s1_op,
    input  logic [EW-1:0]  s1_elem,
    input  logic [VLW-1:0] vl,
    input  logic [AW-1:0]  wr_row,
    input  logic [W-1:0]   scalar,
    input  logic           mask_bit,
    output logic           act,
    output logic           neq,
    output logic           wr_en
);
    localparam int ROWS = 1 << AW;

    logic [W-1:0] bank [ROWS];
    logic [W-1:0] a_q, b_q, rd_q, result;
    logic         in_len;

    // Element position test and result selection for the write stage
    always_comb begin
        in_len = VLW'(s1_elem) < vl;
        act    = s1_valid && in_len;
        neq    = (a_q != scalar);
        wr_en  = act && op_writes_reg(s1_op) && mask_bit;
        unique case (s1_op)
            OP_VV_ADD: result = a_q + b_q;
            OP_VV_SUB: result = a_q - b_q;
            OP_VS_ADD: result = a_q + scalar;
            default:   result = a_q;
        endcase
    end

    // Bank writes: gated pipeline result or host element write
    always_ff @(posedge clk) begin
        if (wr_en)
            bank[wr_row] <= result;
        else if (ld_we)
            bank[ld_row] <= ld_data;
    end

    // Operand capture on issue beats and registered host read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q  <= '0;
            b_q  <= '0;
            rd_q <= '0;
        end else begin
            rd_q <= bank[rd_row];
            if (iss_valid) begin
                a_q <= bank[ra_row];
                b_q <= bank[rb_row];
            end
        end
    end

    assign rd_data = rd_q;

    a_r8_no_host_clash: assert property (@(posedge clk) disable iff (!rst_n)
        ld_we |-> !wr_en);

endmodule

// File: rtl/mvu_mask.sv
// Mask register: one bit per element. Compare beats write the bits of the
// active elements, the fill operation sets all bits, and nothing else
// touches it. Resets to all ones.
module mvu_mask #(
    parameter int MVL   = 64,
    parameter int LANES = 4,
    parameter int EW    = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        busy,
    input  logic                        cmp_en,
    input  logic                        clr_fire,
    input  logic [LANES-1:0]            lane_act,
    input  logic [LANES-1:0]            lane_neq,
    input  logic [LANES-1:0][EW-1:0]    lane_elem,
    output logic [MVL-1:0]              mask_q
);
    // Per-lane bit update on compare beats, full fill on the fill operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (clr_fire) begin
            mask_q <= '1;
        end else if (cmp_en) begin
            for (int j = 0; j < LANES; j++) begin
                if (lane_act[j])
                    mask_q[lane_elem[j]] <= lane_neq[j];
            end
        end
    end

    a_r6_fill_ones: assert property (@(posedge clk) disable iff (!rst_n)
        clr_fire |=> (mask_q == '1));
    a_r5_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(mask_q));

endmodule

// File: rtl/masked_vec_alu.sv
// Masked vector arithmetic unit top: sequencer, mask register and one
// lane per LANES, with host element ports decoded onto the lanes.
// Assumes one command in flight; host element writes are ignored when busy.
module masked_vec_alu
    import mvu_pkg::*;
#(
    parameter int W     = 64,
    parameter int MVL   = 64,
    parameter int LANES = 4,
    parameter int NREG  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         vl_we,
    input  logic [$clog2(MVL+1)-1:0]     vl_in,
    input  logic                         cmd_valid,
    input  logic [2:0]                   cmd_op,
    input  logic [$clog2(NREG)-1:0]      cmd_vd,
    input  logic [$clog2(NREG)-1:0]      cmd_vs1,
    input  logic [$clog2(NREG)-1:0]      cmd_vs2,
    input  logic [W-1:0]                 cmd_scalar,
    input  logic                         ld_we,
    input  logic [$clog2(NREG)-1:0]      ld_reg,
    input  logic [$clog2(MVL)-1:0]       ld_idx,
    input  logic [W-1:0]                 ld_data,
    input  logic [$clog2(NREG)-1:0]      rd_reg,
    input  logic [$clog2(MVL)-1:0]       rd_idx,
    output logic [W-1:0]                 rd_data,
    output logic                         busy,
    output logic                         done,
    output logic [MVL-1:0]               mask_o
);
    localparam int LG  = $clog2(LANES);
    localparam int DW  = $clog2(MVL / LANES);
    localparam int RW  = $clog2(NREG);
    localparam int EW  = $clog2(MVL);
    localparam int VLW = $clog2(MVL+1);
    localparam int AW  = RW + DW;

    logic                      iss_valid, s1_valid, cmp_en, clr_fire;
    logic [AW-1:0]             ra_row, rb_row, wr_row, ld_row, rd_row;
    logic [DW-1:0]             s1_beat;
    vop_e                      s1_op;
    logic [W-1:0]              s1_scalar;
    logic [VLW-1:0]            vl_q;
    logic [LANES-1:0]          lane_act, lane_neq, lane_wr;
    logic [LANES-1:0][EW-1:0]  lane_elem;
    logic [W-1:0]              lane_rd [LANES];
    logic [LG-1:0]             rd_sel_q;

    assign ld_row = {ld_reg, ld_idx[EW-1:LG]};
    assign rd_row = {rd_reg, rd_idx[EW-1:LG]};

    mvu_seq #(.W(W), .MVL(MVL), .LANES(LANES), .NREG(NREG)) seq_i (
        .clk(clk), .rst_n(rst_n), .vl_we(vl_we), .vl_in(vl_in),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_vd(cmd_vd),
        .cmd_vs1(cmd_vs1), .cmd_vs2(cmd_vs2), .cmd_scalar(cmd_scalar),
        .iss_valid(iss_valid), .ra_row(ra_row), .rb_row(rb_row),
        .s1_valid(s1_valid), .s1_beat(s1_beat), .s1_op(s1_op),
        .wr_row(wr_row), .s1_scalar(s1_scalar), .vl_q(vl_q),
        .cmp_en(cmp_en), .clr_fire(clr_fire), .busy(busy), .done(done)
    );

    mvu_mask #(.MVL(MVL), .LANES(LANES), .EW(EW)) mask_i (
        .clk(clk), .rst_n(rst_n), .busy(busy), .cmp_en(cmp_en),
        .clr_fire(clr_fire), .lane_act(lane_act), .lane_neq(lane_neq),
        .lane_elem(lane_elem), .mask_q(mask_o)
    );

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic ld_we_j;
        assign lane_elem[j] = {s1_beat, LG'(j)};
        assign ld_we_j      = ld_we && !busy && (ld_idx[LG-1:0] == LG'(j));

        mvu_lane #(.W(W), .AW(AW), .EW(EW), .VLW(VLW)) lane_i (
            .clk(clk), .rst_n(rst_n),
            .ld_we(ld_we_j), .ld_row(ld_row), .ld_data(ld_data),
            .rd_row(rd_row), .rd_data(lane_rd[j]),
            .iss_valid(iss_valid), .ra_row(ra_row), .rb_row(rb_row),
            .s1_valid(s1_valid), .s1_op(s1_op), .s1_elem(lane_elem[j]),
            .vl(vl_q), .wr_row(wr_row), .scalar(s1_scalar),
            .mask_bit(mask_o[lane_elem[j]]),
            .act(lane_act[j]), .neq(lane_neq[j]), .wr_en(lane_wr[j])
        );
    end

    // Remember which lane the host read addressed
    always_ff @(posedge clk) begin
        if (!rst_n) rd_sel_q <= '0;
        else        rd_sel_q <= rd_idx[LG-1:0];
    end

    assign rd_data = lane_rd[rd_sel_q];

    a_r3_write_in_op: assert property (@(posedge clk) disable iff (!rst_n)
        (|lane_wr) |-> busy);

endmodule

// File: tb/masked_vec_alu_tb_top.sv
`timescale 1ns/1ps
module masked_vec_alu_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vl_we = 1'b0;
    logic [6:0]  vl_in = '0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [1:0]  cmd_vd = '0, cmd_vs1 = '0, cmd_vs2 = '0;
    logic [63:0] cmd_scalar = '0;
    logic        ld_we = 1'b0;
    logic [1:0]  ld_reg = '0;
    logic [5:0]  ld_idx = '0;
    logic [63:0] ld_data = '0;
    logic [1:0]  rd_reg = '0;
    logic [5:0]  rd_idx = '0;
    logic [63:0] rd_data;
    logic        busy, done;
    logic [63:0] mask_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [63:0] rv [4][64];
    logic [63:0] rm;
    int          rvl;

    always #2 clk = ~clk;

    masked_vec_alu dut_i (
        .clk(clk), .rst_n(rst_n), .vl_we(vl_we), .vl_in(vl_in),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_vd(cmd_vd),
        .cmd_vs1(cmd_vs1), .cmd_vs2(cmd_vs2), .cmd_scalar(cmd_scalar),
        .ld_we(ld_we), .ld_reg(ld_reg), .ld_idx(ld_idx), .ld_data(ld_data),
        .rd_reg(rd_reg), .rd_idx(rd_idx), .rd_data(rd_data),
        .busy(busy), .done(done), .mask_o(mask_o)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    task automatic load(input int r, input int i, input logic [63:0] d);
        ld_we = 1'b1; ld_reg = 2'(r); ld_idx = 6'(i); ld_data = d;
        @(posedge clk); #1;
        ld_we = 1'b0;
        rv[r][i] = d;
    endtask

    task automatic load_all_random();
        for (int r = 0; r < 4; r++)
            for (int i = 0; i < 64; i++)
                load(r, i, rnd64());
    endtask

    task automatic readback(input string tag);
        for (int r = 0; r < 4; r++) begin
            for (int i = 0; i < 64; i++) begin
                rd_reg = 2'(r); rd_idx = 6'(i);
                @(posedge clk); #1;
                check($sformatf("%s reg%0d[%0d]", tag, r, i), rd_data, rv[r][i]);
            end
        end
        check({tag, " mask"}, mask_o, rm);
    endtask

    task automatic set_vl(input int v);
        vl_we = 1'b1; vl_in = 7'(v);
        @(posedge clk); #1;
        vl_we = 1'b0;
        rvl = (v > 64) ? 64 : v;
    endtask

    // Issue one operation, check its timing against R7, update the model
    task automatic run_op(input int op, input int vd, input int vs1, input int vs2,
                          input logic [63:0] sc, input string tag);
        int k, cnt;
        logic gap;
        k = (op == 4) ? 2 : ((((rvl + 3) / 4) > 1 ? (rvl + 3) / 4 : 1) + 1);
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_vd = 2'(vd);
        cmd_vs1 = 2'(vs1); cmd_vs2 = 2'(vs2); cmd_scalar = sc;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        cnt = 0; gap = 1'b0;
        if (!busy) gap = 1'b1;
        while (!done && cnt < 100) begin
            @(posedge clk); #1;
            cnt++;
            if (!done && !busy) gap = 1'b1;
        end
        check({tag, " R7 cycles to done"}, 64'(cnt), 64'(k));
        check({tag, " R7 busy before done"}, {63'd0, gap}, 64'd0);
        check({tag, " R7 idle in done cycle"}, {63'd0, busy}, 64'd0);
        @(posedge clk); #1;
        check({tag, " R7 done one cycle"}, {63'd0, done}, 64'd0);
        for (int i = 0; i < rvl; i++) begin
            case (op)
                0: if (rm[i]) rv[vd][i] = rv[vs1][i] + rv[vs2][i];
                1: if (rm[i]) rv[vd][i] = rv[vs1][i] - rv[vs2][i];
                2: if (rm[i]) rv[vd][i] = rv[vs1][i] + sc;
                3: rm[i] = (rv[vs1][i] != sc);
                default: ;
            endcase
        end
        if (op == 4) rm = '1;
    endtask

    task automatic t_reset();
        check("R1 busy after reset", {63'd0, busy}, 64'd0);
        check("R1 done after reset", {63'd0, done}, 64'd0);
        check("R1 mask after reset", mask_o, '1);
        load_all_random();
        run_op(0, 2, 0, 1, 64'd0, "R1 default length add");
        readback("R1 R2 add full");
    endtask

    task automatic t_arith();
        run_op(1, 3, 0, 1, 64'd0, "R2 sub");
        run_op(2, 2, 1, 0, 64'hFFFF_FFFF_FFFF_FFF0, "R2 scalar add wrap");
        readback("R2 arith");
    endtask

    task automatic t_mask();
        for (int i = 0; i < 64; i++)
            load(3, i, ($urandom % 2) ? rnd64() : 64'd0);
        run_op(3, 0, 3, 0, 64'd0, "R5 build mask");
        run_op(0, 2, 0, 1, 64'd0, "R3 masked add slots");
        readback("R3 masked add");
    endtask

    task automatic t_len();
        int lens [9] = '{0, 1, 3, 4, 5, 17, 63, 64, 100};
        for (int n = 0; n < 9; n++) begin
            run_op(4, 0, 0, 0, 64'd0, "R6 fill before length");
            set_vl(lens[n]);
            run_op(2, 1, 0, 0, 64'(n * 7 + 1), $sformatf("R4 len %0d", lens[n]));
            readback($sformatf("R4 len %0d", lens[n]));
        end
    endtask

    task automatic t_cmp();
        set_vl(64);
        for (int i = 0; i < 64; i++)
            load(0, i, (i % 3 == 0) ? 64'd5 : 64'(i));
        run_op(3, 1, 0, 2, 64'd5, "R5 full compare");
        set_vl(20);
        for (int i = 0; i < 64; i++)
            load(0, i, 64'd5);
        run_op(3, 1, 0, 2, 64'd9, "R5 short compare");
        readback("R5 upper bits kept");
    endtask

    task automatic t_fill();
        set_vl(5);
        run_op(4, 2, 1, 0, 64'd0, "R6 fill");
        check("R6 all ones", mask_o, '1);
        readback("R6 regs untouched");
    endtask

    task automatic t_cond_sub();
        set_vl(64);
        for (int i = 0; i < 64; i++) begin
            load(0, i, (i % 4 == 1 || i % 7 == 0) ? 64'd0 : rnd64());
            load(1, i, rnd64());
        end
        run_op(3, 0, 0, 0, 64'd0, "R5 nonzero test");
        run_op(1, 0, 0, 1, 64'd0, "R3 conditional sub");
        run_op(4, 0, 0, 0, 64'd0, "R6 restore mask");
        readback("R3 conditional sub");
    endtask

    task automatic t_ignore();
        logic [63:0] keep;
        set_vl(64);
        keep = rv[3][5];
        cmd_valid = 1'b1; cmd_op = 3'd0; cmd_vd = 2'd2; cmd_vs1 = 2'd0; cmd_vs2 = 2'd1;
        @(posedge clk); #1;
        cmd_op = 3'd1; cmd_vd = 2'd3;
        ld_we = 1'b1; ld_reg = 2'd3; ld_idx = 6'd5; ld_data = ~keep;
        vl_we = 1'b1; vl_in = 7'd3;
        @(posedge clk); #1;
        cmd_valid = 1'b0; ld_we = 1'b0; vl_we = 1'b0;
        while (!done) begin @(posedge clk); #1; end
        @(posedge clk); #1;
        for (int i = 0; i < 64; i++) rv[2][i] = rv[0][i] + rv[1][i];
        check("R8 stays idle after done", {63'd0, busy}, 64'd0);
        run_op(2, 1, 1, 0, 64'd3, "R8 length kept at 64");
        readback("R8 busy inputs ignored");
        cmd_valid = 1'b1; cmd_op = 3'd6; cmd_vd = 2'd0;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        check("R8 reserved op not accepted", {63'd0, busy}, 64'd0);
        @(posedge clk); #1;
        check("R8 reserved op no done", {63'd0, done}, 64'd0);
        readback("R8 reserved op no change");
    endtask

    task automatic t_read();
        load(2, 37, 64'hDEAD_BEEF_0123_4567);
        rd_reg = 2'd2; rd_idx = 6'd37;
        @(posedge clk); #1;
        check("R9 read after write", rd_data, 64'hDEAD_BEEF_0123_4567);
        rd_idx = 6'd38;
        @(posedge clk); #1;
        check("R9 next element", rd_data, rv[2][38]);
    endtask

    initial begin
        rm = '1;
        rvl = 64;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_arith();
        t_mask();
        t_len();
        t_cmp();
        t_fill();
        t_cond_sub();
        t_ignore();
        t_read();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule